// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a fixed set of level-sensitive interrupt lines and drives one interrupt request toward a single processor. Each line has its own configuration word with three fields: a vector number, a 4-bit priority and an enable-blocking mask. A threshold register decides how urgent a request must be before it reaches the processor. The processor takes an interrupt by reading the acknowledge address. That read returns the vector of the winning line and records the line's priority as in service. Later the processor writes the end-of-interrupt address to close the handler.

In-service levels are kept as one bit per priority. While a level is in service, requests at that level and below are held back. A strictly more urgent request can still preempt, so handlers may nest. The bus is a simple synchronous one. A write is taken on the clock edge where the write strobe is high. Read data is registered and is valid the cycle after the read strobe.

Address map: line `i` configuration at address `i` (0 to NUM_SRC-1), threshold at 0x20, acknowledge at 0x21, end-of-interrupt at 0x22.

Top module: `npic_top`

## Requirements
- R1: After reset every line is masked, with priority 0 and vector 0. A configuration read returns 0x8000_0000, the threshold reads 0 and `cpu_irq` is low.
- R2: A configuration word holds the vector in bits [7:0], the priority in bits [11:8] and the mask in bit 31. Mask 0 enables the line and mask 1 blocks it. A read returns the same layout with the other bits zero.
- R3: An acknowledge read returns, in bits [7:0] with the upper bits zero, the vector of the deliverable line of highest priority, and it marks that priority as in service.
- R4: An acknowledge read with no deliverable request returns 0xFF and marks nothing as in service.
- R5: `cpu_irq` is high only for an asserted, unmasked line whose priority is strictly above the threshold. A line with priority 0 is never delivered.
- R6: Between asserted lines of equal priority, the one with the lowest index wins.
- R7: While a level is in service, requests of equal or lower priority are held off, and a strictly higher-priority request is delivered.
- R8: A write of any data to the end-of-interrupt address retires the highest in-service level, which restores the level below it.
- R9: An end-of-interrupt write with nothing in service changes nothing.
- R10: `cpu_irq` falls by the sample point of the cycle after an acknowledge read or a threshold write that removes the only qualifying request.
- R11: A vector or priority written to a line that is in service reads back unchanged until the end-of-interrupt write that retires it, and takes effect then. Its mask bit takes effect at once.
- R12: A masked line is ignored: it raises no `cpu_irq`, and an acknowledge read returns 0xFF for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| irq_src | input | NUM_SRC | level interrupt lines |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | ADDR_W | register address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| cpu_irq | output | 1 | interrupt request to the processor |

## Verification
The assertions assume that reads and writes never happen in the same cycle. They also assume that a line is not re-acknowledged at a level it already holds, which the hold-off rule guarantees. The bench issues one bus operation at a time, on the falling edge, and drives each line low before the end-of-interrupt write for that line. The in-service tracking then always matches the handler order the processor would follow.

// File: rtl/npic_pkg.sv
package npic_pkg;
  localparam int VEC_W  = 8;
  localparam int PRIO_W = 4;
  localparam int NLVL   = 1 << PRIO_W;
  localparam int MASK_BIT = 31;
  localparam logic [VEC_W-1:0] SPURIOUS_VEC = '1;

  typedef struct packed {
    logic              mask;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;

  function automatic src_cfg_t unpack_cfg(input logic [31:0] w);
    src_cfg_t c;
    c.mask = w[MASK_BIT];
    c.prio = w[VEC_W +: PRIO_W];
    c.vec  = w[VEC_W-1:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(input src_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[MASK_BIT] = c.mask;
    w[VEC_W +: PRIO_W] = c.prio;
    w[VEC_W-1:0] = c.vec;
    return w;
  endfunction
endpackage

// File: rtl/npic_src_regs.sv
module npic_src_regs
  import npic_pkg::*;
#(
  parameter int NUM_SRC = 28,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  src_cfg_t          wr_cfg,
  input  logic              take,
  input  logic [IDX_W-1:0]  take_idx,
  input  logic              retire,
  input  logic [PRIO_W-1:0] retire_lvl,
  output src_cfg_t          cfg [NUM_SRC]
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    src_cfg_t shadow;
    logic     pend;
    logic     svc;
    logic     done;

    assign done = retire && svc && (cfg[i].prio == retire_lvl);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i] <= '{mask: 1'b1, prio: '0, vec: '0};
        shadow <= '0;
        pend   <= 1'b0;
        svc    <= 1'b0;
      end else begin
        if (take && take_idx == IDX_W'(i)) svc <= 1'b1;
        if (done) begin
          svc <= 1'b0;
          if (pend) begin
            cfg[i].prio <= shadow.prio;
            cfg[i].vec  <= shadow.vec;
            pend        <= 1'b0;
          end
        end
        if (wr_en && wr_idx == IDX_W'(i)) begin
          cfg[i].mask <= wr_cfg.mask;
          if (svc) begin
            shadow <= wr_cfg;
            pend   <= 1'b1;
          end else begin
            cfg[i].prio <= wr_cfg.prio;
            cfg[i].vec  <= wr_cfg.vec;
          end
        end
      end
    end

    AST_FROZEN_WHILE_SERVED: assert property (@(posedge clk) disable iff (rst)
      (svc && !done) |=> ($stable(cfg[i].prio) && $stable(cfg[i].vec))); // R11
  end
endmodule

// File: rtl/npic_arbiter.sv
module npic_arbiter
  import npic_pkg::*;
#(
  parameter int NUM_SRC = 28,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  input  src_cfg_t           cfg [NUM_SRC],
  output logic               win_valid,
  output logic [PRIO_W-1:0]  win_prio,
  output logic [IDX_W-1:0]   win_idx,
  output logic [VEC_W-1:0]   win_vec
);
  always_comb begin
    win_valid = 1'b0;
    win_prio  = '0;
    win_idx   = '0;
    win_vec   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !cfg[i].mask && cfg[i].prio != '0 &&
          (!win_valid || cfg[i].prio > win_prio)) begin
        win_valid = 1'b1;
        win_prio  = cfg[i].prio;
        win_idx   = IDX_W'(i);
        win_vec   = cfg[i].vec;
      end
    end
  end
endmodule

// File: rtl/npic_isr_stack.sv
module npic_isr_stack
  import npic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic              pop,
  output logic [NLVL-1:0]   isr,
  output logic [PRIO_W-1:0] cur_lvl
);
  always_comb begin
    cur_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (isr[l]) cur_lvl = PRIO_W'(l);
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else if (push) isr[push_lvl] <= 1'b1;
    else if (pop && isr != '0) isr[cur_lvl] <= 1'b0;
  end

  AST_PUSH_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    push |=> isr[$past(push_lvl)]); // R3
  AST_POP_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R8
  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && isr == '0) |=> (isr == '0)); // R9
endmodule

// File: rtl/npic_top.sv
module npic_top
  import npic_pkg::*;
#(
  parameter int NUM_SRC = 28,
  parameter int ADDR_W  = 6,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(32),
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(33),
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(34)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               cpu_irq
);
  src_cfg_t          cfg [NUM_SRC];
  logic              win_valid;
  logic [PRIO_W-1:0] win_prio;
  logic [IDX_W-1:0]  win_idx;
  logic [VEC_W-1:0]  win_vec;
  logic [NLVL-1:0]   isr;
  logic [PRIO_W-1:0] cur_lvl;
  logic [PRIO_W-1:0] thr;
  logic              deliver, is_src, ack_rd, eoi_wr, push;

  assign is_src  = bus_addr < ADDR_W'(NUM_SRC);
  assign ack_rd  = bus_rd && bus_addr == A_ACK;
  assign eoi_wr  = bus_wr && bus_addr == A_EOI;
  assign deliver = win_valid && win_prio > thr && win_prio > cur_lvl;
  assign push    = ack_rd && deliver;
  assign cpu_irq = deliver;

  npic_src_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && is_src), .wr_idx(bus_addr[IDX_W-1:0]),
    .wr_cfg(unpack_cfg(bus_wdata)),
    .take(push), .take_idx(win_idx),
    .retire(eoi_wr && isr != '0), .retire_lvl(cur_lvl),
    .cfg(cfg));

  npic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req(irq_src), .cfg(cfg), .win_valid(win_valid),
    .win_prio(win_prio), .win_idx(win_idx), .win_vec(win_vec));

  npic_isr_stack u_isr (
    .clk(clk), .rst(rst), .push(push), .push_lvl(win_prio),
    .pop(eoi_wr), .isr(isr), .cur_lvl(cur_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      thr       <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_THR) thr <= bus_wdata[PRIO_W-1:0];
      if (bus_rd) begin
        if (is_src)                bus_rdata <= pack_cfg(cfg[bus_addr[IDX_W-1:0]]);
        else if (bus_addr == A_THR) bus_rdata <= 32'(thr);
        else if (ack_rd)            bus_rdata <= 32'(deliver ? win_vec : SPURIOUS_VEC);
        else                        bus_rdata <= '0;
      end
    end
  end

  AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !deliver) |=> (isr == $past(isr))); // R4
  AST_IRQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (win_prio > cur_lvl && win_prio != '0)); // R7
endmodule

// File: tb/npic_top_bench.sv
module npic_top_bench;
  localparam int NS = 28;
  logic        clk = 0, rst = 1;
  logic [NS-1:0] src = '0;
  logic        wr = 0, rd = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  npic_top u_npic_top (.clk(clk), .rst(rst), .irq_src(src), .bus_wr(wr),
    .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .cpu_irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = 6'(a); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = 6'(a);
    @(negedge clk); rd = 0; d = rdata;
  endtask

  function automatic logic [31:0] cw(input bit m, input int p, input int v);
    return {m, 19'b0, 4'(p), 8'(v)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    rd_reg(5, d);  chk("R1 cfg", d, 32'h8000_0000);
    rd_reg(32, d); chk("R1 thr", d, 0);
    src = '1;
    @(negedge clk); chk("R12 masked irq", 32'(irq), 0);
    rd_reg(33, d); chk("R12 masked ack", d, 32'hFF);
    src = '0;
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr_reg(3, cw(0, 5, 8'h43));
    rd_reg(3, d); chk("R2 layout", d, 32'h0000_0543);
    src[3] = 1;
    @(negedge clk); chk("R5 deliver", 32'(irq), 1);
    rd_reg(33, d); chk("R3 ack vec", d, 32'h43);
    chk("R10 drop after ack", 32'(irq), 0);
    src[3] = 0; wr_reg(34, 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr_reg(32, 5); src[3] = 1;
    @(negedge clk); chk("R5 equal thr", 32'(irq), 0);
    rd_reg(33, d); chk("R4 spurious", d, 32'hFF);
    wr_reg(32, 4); chk("R5 above thr", 32'(irq), 1);
    wr_reg(32, 5); chk("R10 drop after thr", 32'(irq), 0);
    wr_reg(32, 0); src[3] = 0;
    wr_reg(10, cw(0, 0, 8'h10)); src[10] = 1;
    @(negedge clk); chk("R5 prio zero", 32'(irq), 0);
    src[10] = 0;
  endtask

  task automatic t_tie();
    logic [31:0] d;
    wr_reg(9, cw(0, 6, 8'h99)); wr_reg(7, cw(0, 6, 8'h77));
    src[9] = 1; src[7] = 1;
    rd_reg(33, d); chk("R6 tie low index", d, 32'h77);
    src[7] = 0; wr_reg(34, 0);
    rd_reg(33, d); chk("R6 second", d, 32'h99);
    src[9] = 0; wr_reg(34, 0);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr_reg(12, cw(0, 5, 8'hC5)); wr_reg(13, cw(0, 4, 8'hD4));
    wr_reg(14, cw(0, 9, 8'hE9));
    src[3] = 1;
    rd_reg(33, d); chk("R3 nest first", d, 32'h43);
    src[12] = 1; src[13] = 1;
    @(negedge clk); chk("R7 hold equal/lower", 32'(irq), 0);
    rd_reg(33, d); chk("R4 held ack", d, 32'hFF);
    src[14] = 1;
    @(negedge clk); chk("R7 higher preempts", 32'(irq), 1);
    rd_reg(33, d); chk("R7 nested vec", d, 32'hE9);
    src[14] = 0; wr_reg(34, 0);
    chk("R8 back to level 5", 32'(irq), 0);
    src[3] = 0; wr_reg(34, 0);
    chk("R8 level retired", 32'(irq), 1);
    rd_reg(33, d); chk("R8 next winner", d, 32'hC5);
    src[12] = 0; wr_reg(34, 0);
    rd_reg(33, d); chk("R8 lower now", d, 32'hD4);
    src[13] = 0; wr_reg(34, 0);
    wr_reg(34, 0);
    src[13] = 1;
    @(negedge clk); chk("R9 empty eoi", 32'(irq), 1);
    rd_reg(33, d); chk("R9 ack after", d, 32'hD4);
    src[13] = 0; wr_reg(34, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr_reg(3, cw(1, 5, 8'h43)); src[3] = 1;
    @(negedge clk); chk("R12 mask irq", 32'(irq), 0);
    rd_reg(33, d); chk("R12 mask ack", d, 32'hFF);
    wr_reg(3, cw(0, 5, 8'h43)); chk("R2 unmask", 32'(irq), 1);
    src[3] = 0;
  endtask

  task automatic t_defer();
    logic [31:0] d;
    src[3] = 1;
    rd_reg(33, d); chk("R11 ack", d, 32'h43);
    wr_reg(3, cw(0, 7, 8'h55));
    rd_reg(3, d); chk("R11 held", d, 32'h0000_0543);
    src[3] = 0; wr_reg(34, 0);
    rd_reg(3, d); chk("R11 applied", d, 32'h0000_0755);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_basic(); t_threshold(); t_tie(); t_nest(); t_mask(); t_defer();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule